// File: doc/BRIEF.md
# DMA Request Router with Synchronized Batch Gating

The router connects a set of peripheral request lines to the request inputs of two DMA controllers. Each output channel has one 32-bit control word. The word picks which input request line feeds that channel. A request here is one clock cycle in which the selected line is high. Output channels 0 to 6 feed controller A channels 1 to 7. Output channels 7 to 13 feed controller B channels 1 to 7.

A channel can also be gated by one of several asynchronous synchronization inputs. Each detected edge of the chosen polarity opens a window for a programmed number of requests. Any requests beyond that number are blocked until the next edge.

Each channel can emit a one-cycle event pulse after the last forwarded request of a batch. An edge that arrives while a batch is still open sets a sticky overrun flag, which can raise a shared interrupt.

Top module: `req_router`

## Requirements
- R1: With gating off (bit 16 = 0), each cycle in which the selected line is high produces exactly one high cycle on the channel's request output, one clock later.
- R2: Selection value 0, and any selection value at or above NUM_REQ, forwards nothing. Input line 0 is never forwarded.
- R3: The request outputs of channel c appear on req_a[c] for c below CH_PER_CTRL, and on req_b[c-CH_PER_CTRL] otherwise.
- R4: The control word layout is as follows. Bits [7:0] select the input line. Bit 8 enables the overrun interrupt and bit 9 enables the event pulse. Bit 16 enables gating. Bits [18:17] set the edge mode. Bits [23:19] hold the batch length minus one. Bits [28:24] select the sync input.
- R5: Sync inputs pass through two flops before edge detection. Edge mode 01 reacts to rising edges, 10 to falling edges, 11 to both, and 00 to none. A sync selection at or above NUM_SYNC never produces an edge.
- R6: With gating on, each detected edge allows exactly (bits [23:19] + 1) further requests. Requests after that are blocked until the next edge.
- R7: A change on a sync input is first accepted on the third rising clock edge after it. Requests sampled on that third edge are not yet forwarded.
- R8: With bit 9 set, a one-cycle pulse appears on evt_out the cycle after the request output that ended a batch. With gating off, every forwarded request ends a batch.
- R9: An edge that arrives when requests would still remain open after the current cycle sets ovr_flag for that channel. The flag stays set until an ovr_clr pulse for that channel. If a set and a clear fall in the same cycle, the set wins.
- R10: ovr_irq is high exactly when some channel has both its overrun flag and its bit 8 set.
- R11: A write to a channel discards any remaining batch allowance. A write with cfg_idx at or above the channel count changes nothing.
- R12: During synchronous reset, every control word, counter, flag and output returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_idx | input | IDX_W | Channel written |
| cfg_data | input | 32 | Control word value |
| req_in | input | NUM_REQ | Peripheral request lines, indexed by selection value |
| sync_in | input | NUM_SYNC | Asynchronous synchronization inputs |
| ovr_clr | input | NUM_CH | Per-channel overrun flag clear |
| req_a | output | CH_PER_CTRL | Requests to controller A channels 1 and up |
| req_b | output | CH_PER_CTRL | Requests to controller B channels 1 and up |
| evt_out | output | NUM_CH | Per-channel end-of-batch event pulses |
| ovr_flag | output | NUM_CH | Per-channel sticky overrun flags |
| ovr_irq | output | 1 | Overrun interrupt |

## Verification
The hardest states to reach are a gated channel holding an unfinished allowance at the moment a second edge arrives, and a write that lands while an allowance is still open. The directed part reaches both by programming a long batch (up to 32) on a request line held quiet. It then toggles the sync input twice, or rewrites the channel between the edge and the requests. The random part toggles sync inputs slowly while requests stay dense or sparse, and rewrites channels at random. This covers the overlap of edges, batch ends and writes, with every output compared each cycle against a bench model.

// File: rtl/req_router_pkg.sv
package req_router_pkg;

    localparam int CFG_W   = 32;
    localparam int SEL_W   = 8;
    localparam int BATCH_W = 5;
    localparam int SSEL_W  = 5;
    localparam int LEFT_W  = BATCH_W + 1;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    // Control word, most significant field first (32 bits in total)
    typedef struct packed {
        logic [2:0]         rsvd_hi;
        logic [SSEL_W-1:0]  sync_sel;
        logic [BATCH_W-1:0] batch_m1;
        edge_mode_e         edge_mode;
        logic               gate_en;
        logic [5:0]         rsvd_lo;
        logic               evt_en;
        logic               ovr_ie;
        logic [SEL_W-1:0]   line_sel;
    } chan_cfg_t;

    function automatic logic edge_match(edge_mode_e mode, logic rise, logic fall);
        logic want_rise;
        logic want_fall;
        want_rise = (mode == EDGE_RISE) || (mode == EDGE_BOTH);
        want_fall = (mode == EDGE_FALL) || (mode == EDGE_BOTH);
        return (want_rise && rise) || (want_fall && fall);
    endfunction

    function automatic logic [LEFT_W-1:0] batch_len(logic [BATCH_W-1:0] m1);
        return {1'b0, m1} + LEFT_W'(1);
    endfunction

endpackage

// File: rtl/req_router_sync.sv
module req_router_sync #(
    parameter int NUM_SYNC = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SYNC-1:0] sync_in,
    output logic [NUM_SYNC-1:0] rise_o,
    output logic [NUM_SYNC-1:0] fall_o
);

    logic [NUM_SYNC-1:0] meta_q;
    logic [NUM_SYNC-1:0] stab_q;
    logic [NUM_SYNC-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= sync_in;
            stab_q <= meta_q;
            prev_q <= stab_q;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_SYNC; g++) begin : g_edge
            assign rise_o[g] = stab_q[g] & ~prev_q[g];
            assign fall_o[g] = ~stab_q[g] & prev_q[g];
        end
    endgenerate

endmodule

// File: rtl/req_router_chan.sv
module req_router_chan
    import req_router_pkg::*;
#(
    parameter int NUM_REQ  = 40,
    parameter int NUM_SYNC = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [CFG_W-1:0]    wr_data,
    input  logic                clr_ovr,
    input  logic [NUM_REQ-1:0]  req_vec,
    input  logic [NUM_SYNC-1:0] rise_vec,
    input  logic [NUM_SYNC-1:0] fall_vec,
    output logic                req_o,
    output logic                evt_o,
    output logic                ovr_o,
    output logic                irq_o
);

    chan_cfg_t         cfg_q;
    logic [LEFT_W-1:0] left_q;
    logic              last_q;

    logic              sel_req;
    logic              sync_r;
    logic              sync_f;
    logic              edge_hit;
    logic              fwd;
    logic              is_last;
    logic [LEFT_W-1:0] left_after;
    logic              ovr_set;

    // Request select: value 0 and values past the last line give 0
    always_comb begin
        sel_req = 1'b0;
        for (int k = 1; k < NUM_REQ; k++) begin
            if (int'(cfg_q.line_sel) == k) sel_req = req_vec[k];
        end
    end

    // Sync input select: out-of-range selection yields no edges
    always_comb begin
        sync_r = 1'b0;
        sync_f = 1'b0;
        for (int k = 0; k < NUM_SYNC; k++) begin
            if (int'(cfg_q.sync_sel) == k) begin
                sync_r = rise_vec[k];
                sync_f = fall_vec[k];
            end
        end
    end

    always_comb begin
        edge_hit   = cfg_q.gate_en && edge_match(cfg_q.edge_mode, sync_r, sync_f);
        fwd        = cfg_q.gate_en ? (sel_req && (left_q != '0)) : sel_req;
        is_last    = !cfg_q.gate_en || (left_q == LEFT_W'(1));
        left_after = left_q - {{(LEFT_W-1){1'b0}}, fwd};
        ovr_set    = edge_hit && !wr_en && (left_after != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            left_q <= '0;
            last_q <= 1'b0;
            req_o  <= 1'b0;
            evt_o  <= 1'b0;
            ovr_o  <= 1'b0;
        end else begin
            req_o  <= fwd;
            last_q <= fwd && is_last;
            evt_o  <= last_q && cfg_q.evt_en;
            ovr_o  <= ovr_set || (ovr_o && !clr_ovr);
            if (wr_en) begin
                cfg_q  <= chan_cfg_t'(wr_data);
                left_q <= '0;
            end else if (edge_hit) begin
                left_q <= batch_len(cfg_q.batch_m1);
            end else if (cfg_q.gate_en && fwd) begin
                left_q <= left_after;
            end
        end
    end

    assign irq_o = ovr_o && cfg_q.ovr_ie;

    logic unused_chan_bits;
    assign unused_chan_bits = ^{cfg_q.rsvd_hi, cfg_q.rsvd_lo, req_vec[0]};

endmodule

// File: rtl/req_router.sv
module req_router
    import req_router_pkg::*;
#(
    parameter int  NUM_REQ     = 40,
    parameter int  NUM_SYNC    = 8,
    parameter int  CH_PER_CTRL = 7,
    localparam int NUM_CH      = 2 * CH_PER_CTRL,
    localparam int IDX_W       = $clog2(NUM_CH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [IDX_W-1:0]       cfg_idx,
    input  logic [CFG_W-1:0]       cfg_data,
    input  logic [NUM_REQ-1:0]     req_in,
    input  logic [NUM_SYNC-1:0]    sync_in,
    input  logic [NUM_CH-1:0]      ovr_clr,
    output logic [CH_PER_CTRL-1:0] req_a,
    output logic [CH_PER_CTRL-1:0] req_b,
    output logic [NUM_CH-1:0]      evt_out,
    output logic [NUM_CH-1:0]      ovr_flag,
    output logic                   ovr_irq
);

    logic [NUM_SYNC-1:0] rise_vec;
    logic [NUM_SYNC-1:0] fall_vec;
    logic [NUM_CH-1:0]   req_vec;
    logic [NUM_CH-1:0]   irq_vec;

    req_router_sync #(.NUM_SYNC(NUM_SYNC)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .sync_in(sync_in),
        .rise_o (rise_vec),
        .fall_o (fall_vec)
    );

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_chan
            logic wr_hit;
            assign wr_hit = cfg_we && (cfg_idx == IDX_W'(c));

            req_router_chan #(
                .NUM_REQ (NUM_REQ),
                .NUM_SYNC(NUM_SYNC)
            ) u_chan (
                .clk     (clk),
                .rst     (rst),
                .wr_en   (wr_hit),
                .wr_data (cfg_data),
                .clr_ovr (ovr_clr[c]),
                .req_vec (req_in),
                .rise_vec(rise_vec),
                .fall_vec(fall_vec),
                .req_o   (req_vec[c]),
                .evt_o   (evt_out[c]),
                .ovr_o   (ovr_flag[c]),
                .irq_o   (irq_vec[c])
            );
        end
    endgenerate

    // Controller split: low half to controller A, high half to controller B
    assign req_a   = req_vec[CH_PER_CTRL-1:0];
    assign req_b   = req_vec[NUM_CH-1:CH_PER_CTRL];
    assign ovr_irq = |irq_vec;

endmodule

// File: rtl/req_router_chk.sv
module req_router_chk #(
    parameter int  NUM_REQ     = 40,
    parameter int  CH_PER_CTRL = 7,
    localparam int NUM_CH      = 2 * CH_PER_CTRL
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NUM_REQ-1:0]     req_in,
    input logic [NUM_CH-1:0]      ovr_clr,
    input logic [CH_PER_CTRL-1:0] req_a,
    input logic [CH_PER_CTRL-1:0] req_b,
    input logic [NUM_CH-1:0]      evt_out,
    input logic [NUM_CH-1:0]      ovr_flag,
    input logic                   ovr_irq
);

    logic [NUM_CH-1:0] req_all;
    assign req_all = {req_b, req_a};

    logic unused_chk;
    assign unused_chk = req_in[0];

    // A forwarded request needs a high line other than line 0 one cycle before
    assert_req_has_source_R2: assert property (@(posedge clk) disable iff (rst)
        (req_all != '0) |-> $past(req_in[NUM_REQ-1:1] != '0));

    // An event only follows a request output on the same channel
    assert_evt_after_req_R8: assert property (@(posedge clk) disable iff (rst)
        (evt_out != '0) |-> ((evt_out & ~$past(req_all)) == '0));

    // Flags persist unless cleared
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(ovr_flag) != '0) |-> ((($past(ovr_flag) & ~$past(ovr_clr)) & ~ovr_flag) == '0));

    // Interrupt requires a raised flag
    assert_irq_has_flag_R10: assert property (@(posedge clk) disable iff (rst)
        ovr_irq |-> (ovr_flag != '0));

endmodule

bind req_router req_router_chk #(
    .NUM_REQ    (NUM_REQ),
    .CH_PER_CTRL(CH_PER_CTRL)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .req_in  (req_in),
    .ovr_clr (ovr_clr),
    .req_a   (req_a),
    .req_b   (req_b),
    .evt_out (evt_out),
    .ovr_flag(ovr_flag),
    .ovr_irq (ovr_irq)
);

// File: tb/req_router_test.sv
`timescale 1ns/1ps
module req_router_test;

    localparam int NR  = 40;
    localparam int NS  = 8;
    localparam int CPC = 7;
    localparam int NCH = 2 * CPC;
    localparam int IW  = $clog2(NCH);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cfg_we = 1'b0;
    logic [IW-1:0]  cfg_idx = '0;
    logic [31:0]    cfg_data = '0;
    logic [NR-1:0]  req_in = '0;
    logic [NS-1:0]  sync_in = '0;
    logic [NCH-1:0] ovr_clr = '0;
    logic [CPC-1:0] req_a;
    logic [CPC-1:0] req_b;
    logic [NCH-1:0] evt_out;
    logic [NCH-1:0] ovr_flag;
    logic           ovr_irq;

    req_router #(.NUM_REQ(NR), .NUM_SYNC(NS), .CH_PER_CTRL(CPC)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .req_in(req_in), .sync_in(sync_in), .ovr_clr(ovr_clr),
        .req_a(req_a), .req_b(req_b), .evt_out(evt_out),
        .ovr_flag(ovr_flag), .ovr_irq(ovr_irq)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit chk_on = 0;
    bit done = 0;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Control word per R4
    function automatic logic [31:0] mk_cfg(int line, bit ie, bit ev, bit gate,
                                           int mode, int bm1, int ss);
        return {3'b0, 5'(ss), 5'(bm1), 2'(mode), gate, 6'b0, ev, ie, 8'(line)};
    endfunction

    // ---------------- reference model ----------------
    logic [31:0]    m_cfg [NCH];
    int             m_left [NCH];
    logic [NCH-1:0] exp_req, exp_last, exp_evt, exp_ovr;
    logic [NS-1:0]  m_s1, m_s2, m_s3;

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin
                m_cfg[c]  <= '0;
                m_left[c] <= 0;
            end
            exp_req <= '0; exp_last <= '0; exp_evt <= '0; exp_ovr <= '0;
            m_s1 <= '0; m_s2 <= '0; m_s3 <= '0;
        end else begin
            m_s1 <= sync_in; m_s2 <= m_s1; m_s3 <= m_s2;
            for (int c = 0; c < NCH; c++) begin
                automatic logic [31:0] w = m_cfg[c];
                automatic int ln = int'(w[7:0]);
                automatic int ss = int'(w[28:24]);
                automatic int bm = int'(w[23:19]);
                automatic bit gate = w[16];
                automatic bit sel = (ln != 0 && ln < NR) ? req_in[ln] : 1'b0;
                automatic bit r = (ss < NS) ? (m_s2[ss] & ~m_s3[ss]) : 1'b0;
                automatic bit f = (ss < NS) ? (~m_s2[ss] & m_s3[ss]) : 1'b0;
                automatic bit hit = gate && ((w[17] && r) || (w[18] && f));
                automatic bit fwd = gate ? (sel && m_left[c] != 0) : sel;
                automatic bit wr = cfg_we && (int'(cfg_idx) == c);
                automatic int after = m_left[c] - (fwd ? 1 : 0);
                exp_req[c]  <= fwd;
                exp_last[c] <= fwd && (!gate || m_left[c] == 1);
                exp_evt[c]  <= exp_last[c] && w[9];
                if (hit && !wr && after != 0) exp_ovr[c] <= 1'b1;
                else if (ovr_clr[c])          exp_ovr[c] <= 1'b0;
                if (wr) begin
                    m_left[c] <= 0;
                    m_cfg[c]  <= cfg_data;
                end else if (hit) m_left[c] <= bm + 1;
                else if (gate && fwd) m_left[c] <= after;
            end
        end
    end

    function automatic logic exp_irq_f();
        logic v = 1'b0;
        for (int c = 0; c < NCH; c++) v |= exp_ovr[c] & m_cfg[c][8];
        return v;
    endfunction

    // Cycle compare against the model
    always @(negedge clk) begin
        if (chk_on && !rst) begin
            check("R1 R3 request outputs", 64'({req_b, req_a}), 64'(exp_req));
            check("R8 event outputs", 64'(evt_out), 64'(exp_evt));
            check("R9 overrun flags", 64'(ovr_flag), 64'(exp_ovr));
            check("R10 overrun irq", 64'(ovr_irq), 64'(exp_irq_f()));
        end
    end

    // Pulse counters
    int cnt_req [NCH];
    int cnt_evt [NCH];
    initial for (int c = 0; c < NCH; c++) begin cnt_req[c] = 0; cnt_evt[c] = 0; end
    always @(negedge clk) begin
        if (!rst) begin
            for (int c = 0; c < NCH; c++) begin
                cnt_req[c] += int'({req_b, req_a}[c]);
                cnt_evt[c] += int'(evt_out[c]);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr_cfg(int idx, logic [31:0] d);
        cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_data = d;
        tick(1);
        cfg_we = 1'b0;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int b0, b1, e0;
        void'($urandom(32'd5150));
        tick(4);
        check("R12 reset outputs", 64'({req_b, req_a, evt_out, ovr_flag, ovr_irq}), 64'(0));
        rst = 1'b0;
        chk_on = 1'b1;
        tick(2);
        check("R12 outputs after reset", 64'({req_b, req_a, evt_out, ovr_flag, ovr_irq}), 64'(0));

        // R1 pass-through
        wr_cfg(0, mk_cfg(5, 0, 0, 0, 0, 0, 0));
        b0 = cnt_req[0];
        req_in[5] = 1'b1; tick(10); req_in[5] = 1'b0; tick(3);
        check("R1 pass-through count", 64'(cnt_req[0] - b0), 64'(10));

        // R2 id 0 and out-of-range id
        wr_cfg(2, mk_cfg(NR + 3, 0, 0, 0, 0, 0, 0));
        b0 = cnt_req[1]; b1 = cnt_req[2];
        req_in = '1; tick(10); req_in = '0; tick(3);
        check("R2 id zero silent", 64'(cnt_req[1] - b0), 64'(0));
        check("R2 out-of-range id silent", 64'(cnt_req[2] - b1), 64'(0));

        // R3 mapping: channel 7 -> controller B channel 1
        wr_cfg(7, mk_cfg(6, 0, 0, 0, 0, 0, 0));
        b0 = cnt_req[7]; b1 = cnt_req[6];
        req_in[6] = 1'b1; tick(8); req_in[6] = 1'b0; tick(3);
        check("R3 req_b[0] count", 64'(cnt_req[7] - b0), 64'(8));
        check("R3 req_a[6] idle", 64'(cnt_req[6] - b1), 64'(0));

        // R11 write to an out-of-range index leaves channel 7 intact
        wr_cfg(15, 32'h0);
        b0 = cnt_req[7];
        req_in[6] = 1'b1; tick(5); req_in[6] = 1'b0; tick(3);
        check("R11 out-of-range index ignored", 64'(cnt_req[7] - b0), 64'(5));

        // R6 R5 R8 batch of 3 on rising edge
        wr_cfg(3, mk_cfg(7, 0, 1, 1, 1, 2, 1));
        req_in[7] = 1'b1; tick(4);
        b0 = cnt_req[3]; e0 = cnt_evt[3];
        sync_in[1] = 1'b1; tick(15);
        check("R6 batch length 3", 64'(cnt_req[3] - b0), 64'(3));
        check("R8 one event per batch", 64'(cnt_evt[3] - e0), 64'(1));
        sync_in[1] = 1'b0; tick(15);
        check("R5 falling edge ignored in rise mode", 64'(cnt_req[3] - b0), 64'(3));

        // R7 acceptance latency: third edge after change forwards nothing yet
        wr_cfg(3, mk_cfg(7, 0, 0, 1, 1, 0, 1));
        tick(2);
        b0 = cnt_req[3];
        sync_in[1] = 1'b1; tick(3);
        check("R7 nothing forwarded before acceptance", 64'(cnt_req[3] - b0), 64'(0));
        tick(1);
        check("R7 first forwarded request", 64'(cnt_req[3] - b0), 64'(1));
        sync_in[1] = 1'b0; tick(6);

        // R5 both edges, batch of 1, no overrun when batch consumed
        wr_cfg(3, mk_cfg(7, 0, 0, 1, 3, 0, 1));
        b0 = cnt_req[3];
        sync_in[1] = 1'b1; tick(10);
        sync_in[1] = 1'b0; tick(10);
        check("R5 both-edge mode count", 64'(cnt_req[3] - b0), 64'(2));
        check("R9 no overrun when consumed", 64'(ovr_flag[3]), 64'(0));

        // R5 edge mode none
        wr_cfg(3, mk_cfg(7, 0, 0, 1, 0, 0, 1));
        b0 = cnt_req[3];
        sync_in[1] = 1'b1; tick(10); sync_in[1] = 1'b0; tick(10);
        check("R5 mode none forwards nothing", 64'(cnt_req[3] - b0), 64'(0));
        req_in[7] = 1'b0;

        // R9 R10 overrun with open batch of 32
        wr_cfg(4, mk_cfg(8, 1, 0, 1, 1, 31, 2));
        sync_in[2] = 1'b1; tick(6);
        sync_in[2] = 1'b0; tick(6);
        check("R9 no flag after first edge", 64'(ovr_flag[4]), 64'(0));
        sync_in[2] = 1'b1; tick(6);
        check("R9 overrun flag set", 64'(ovr_flag[4]), 64'(1));
        check("R10 overrun irq", 64'(ovr_irq), 64'(1));
        ovr_clr[4] = 1'b1; tick(1); ovr_clr[4] = 1'b0; tick(1);
        check("R9 flag cleared", 64'(ovr_flag[4]), 64'(0));
        check("R10 irq cleared", 64'(ovr_irq), 64'(0));
        sync_in[2] = 1'b0; tick(4);

        // R11 write discards open allowance
        wr_cfg(5, mk_cfg(9, 0, 0, 1, 1, 3, 3));
        sync_in[3] = 1'b1; tick(6);
        wr_cfg(5, mk_cfg(9, 0, 0, 1, 1, 3, 3));
        b0 = cnt_req[5];
        req_in[9] = 1'b1; tick(10); req_in[9] = 1'b0; tick(3);
        check("R11 write discards batch", 64'(cnt_req[5] - b0), 64'(0));
        sync_in[3] = 1'b0; tick(4);

        // Random phase, checked against the model every cycle
        for (int i = 0; i < 5000; i++) begin
            automatic bit dense = ((i / 500) % 2) == 0;
            for (int k = 0; k < NR; k++)
                req_in[k] = dense ? ($urandom_range(0, 3) != 0) : ($urandom_range(0, 7) == 0);
            for (int k = 0; k < NS; k++)
                if ($urandom_range(0, 15) == 0) sync_in[k] = ~sync_in[k];
            for (int k = 0; k < NCH; k++)
                ovr_clr[k] = ($urandom_range(0, 31) == 0);
            if ($urandom_range(0, 39) == 0) begin
                cfg_we   = 1'b1;
                cfg_idx  = IW'($urandom_range(0, 15));
                cfg_data = mk_cfg($urandom_range(0, NR + 8), 1'($urandom),
                                  1'($urandom), 1'($urandom), $urandom_range(0, 3),
                                  ($urandom_range(0, 7) == 0) ? 31 : $urandom_range(0, 5),
                                  $urandom_range(0, 9)) | ($urandom & 32'hE000_FC00);
            end else begin
                cfg_we = 1'b0;
            end
            tick(1);
        end
        cfg_we = 1'b0; req_in = '0; ovr_clr = '0;
        tick(5);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog R12: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule